// File: doc/BRIEF.md
# Flash Program/Erase Control Register

This block is a single control register for a flash programming controller. It stores the operation selects (program, erase, verify), a high-voltage enable, two erase-block-size select bits and two pump-clock divide select bits. Every write is filtered through a set of cross-bit interlocks before it is stored. As a result, the stored value never holds a combination that the array and the charge pump cannot accept.

The register also produces a pump-clock tick. This tick is a one-cycle pulse at the bus clock rate divided by 1, 2 or 4, chosen by the divide bits. It is active only while high voltage is enabled. The block has no address: one write strobe with data, and a read bus that always shows the stored value.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset, rd_data_o is 0x00, all decoded outputs are 0 and pump_tick_o is 0.
- R2: The register bit layout is prog=bit0, erase=bit1, verify=bit2, hv=bit3, blk=bits5:4, div=bits7:6. After any write, prog and erase are never both 1. A write that sets both, or sets one while the other is stored as 1, leaves the stored pair unchanged.
- R3: hv can be stored as 1 only if prog or erase is 1 in the value that results from the same write. A write of 1 to hv is otherwise dropped.
- R4: While the stored hv is 1, a write of 1 to verify is dropped.
- R5: A write that raises hv from 0 to 1 leaves verify at 0, even if verify was 1 before or is written as 1.
- R6: A write that leaves both prog and erase at 0 also clears hv.
- R7: The blk and div fields store any written value unchanged. rd_data_o and the decoded outputs show the stored value one clock after the write.
- R8: While hv is 1, pump_tick_o is high for one cycle in every f cycles, with f=1 for div=00, f=2 for 01, f=2 for 10 and f=4 for 11. The first tick comes in the f-th cycle after the write that set hv.
- R9: pump_tick_o is 0 in every cycle in which the stored hv is 0.
- R10: A write that changes div restarts the divide count. The next tick comes in the f-th cycle after that write.
- R11: A cycle with wr_en_i low leaves the stored value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Stored register value |
| prog_o | output | 1 | Program select |
| erase_o | output | 1 | Erase select |
| verify_o | output | 1 | Verify select |
| hv_en_o | output | 1 | High voltage / pump on |
| blk_sel_o | output | 2 | Erase block size select |
| div_sel_o | output | 2 | Pump divide select |
| pump_tick_o | output | 1 | Pump clock enable pulse |

## Verification
A write presented before a rising edge is stored on that edge. Its filtered value appears on rd_data_o and the decoded outputs in the cycle that follows, so the bench drives on the falling edge and compares one falling edge later. The tick comes from the registered divide count. After the write that sets hv or changes div, the sample taken at the next falling edge counts as cycle 0, and a tick is expected in cycles where (index mod f) equals f-1. The bench checks every one of these cycles, and checks that the tick stays low whenever hv is 0.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  typedef struct packed {
    logic [1:0] div;
    logic [1:0] blk;
    logic       hv;
    logic       verify;
    logic       erase;
    logic       prog;
  } ctl_reg_t;

  localparam int unsigned MAX_DIV = 4;

  function automatic int unsigned div_factor(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01,
      2'b10:   return 2;
      default: return MAX_DIV;
    endcase
  endfunction

endpackage

// File: rtl/flash_ctl_interlock.sv
module flash_ctl_interlock
  import flash_ctl_pkg::*;
(
  input  ctl_reg_t cur_i,
  input  ctl_reg_t wdata_i,
  output ctl_reg_t nxt_o
);

  logic pair_block;
  logic op_sel;

  // the pair is held if the write ends with both set, or sets one while the other is stored
  always_comb begin
    pair_block = (wdata_i.prog & wdata_i.erase)
               | (wdata_i.prog  & ~cur_i.prog  & cur_i.erase)
               | (wdata_i.erase & ~cur_i.erase & cur_i.prog);
    nxt_o       = wdata_i;
    nxt_o.prog  = pair_block ? cur_i.prog  : wdata_i.prog;
    nxt_o.erase = pair_block ? cur_i.erase : wdata_i.erase;
    op_sel      = nxt_o.prog | nxt_o.erase;
    nxt_o.hv    = wdata_i.hv & op_sel;
    nxt_o.verify = wdata_i.verify & ~cur_i.hv & ~nxt_o.hv;
  end

endmodule

// File: rtl/flash_ctl_pump_div.sv
module flash_ctl_pump_div
  import flash_ctl_pkg::*;
#(
  parameter int unsigned MAX_F = MAX_DIV
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hv_i,
  input  logic [1:0] div_sel_i,
  input  logic       restart_i,
  output logic       tick_o
);

  localparam int unsigned CNT_W = (MAX_F > 1) ? $clog2(MAX_F) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb last = CNT_W'(div_factor(div_sel_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!hv_i || restart_i)  cnt_q <= '0;
    else if (cnt_q == last)       cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = hv_i && (cnt_q == last);

  a_r8_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && last != '0 && !restart_i) |=> !tick_o);

  a_r10_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
  import flash_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       prog_o,
  output logic       erase_o,
  output logic       verify_o,
  output logic       hv_en_o,
  output logic [1:0] blk_sel_o,
  output logic [1:0] div_sel_o,
  output logic       pump_tick_o
);

  ctl_reg_t reg_q, reg_d, filt;
  logic     div_restart;

  flash_ctl_interlock u_lock (
    .cur_i   (reg_q),
    .wdata_i (ctl_reg_t'(wr_data_i)),
    .nxt_o   (filt)
  );

  always_comb begin
    reg_d       = wr_en_i ? filt : reg_q;
    div_restart = (reg_d.div != reg_q.div);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= '0;
    else         reg_q <= reg_d;
  end

  flash_ctl_pump_div #(.MAX_F(MAX_DIV)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hv_i      (reg_q.hv),
    .div_sel_i (reg_q.div),
    .restart_i (div_restart),
    .tick_o    (pump_tick_o)
  );

  assign rd_data_o = reg_q;
  assign prog_o    = reg_q.prog;
  assign erase_o   = reg_q.erase;
  assign verify_o  = reg_q.verify;
  assign hv_en_o   = reg_q.hv;
  assign blk_sel_o = reg_q.blk;
  assign div_sel_o = reg_q.div;

  a_r2_pair_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_o && erase_o));

  a_r2_pair_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[0] && wr_data_i[1]) |=> $stable({prog_o, erase_o}));

  a_r3_hv_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> (prog_o || erase_o));

  a_r4_verify_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv_en_o && wr_en_i && wr_data_i[2]) |=> !verify_o);

  a_r5_verify_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hv_en_o) |-> !verify_o);

  a_r9_tick_needs_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hv_en_o |-> !pump_tick_o);

  a_r11_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));

endmodule

// File: tb/flash_ctl_reg_tb.sv
module flash_ctl_reg_tb;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       prog, erase, verify, hv;
  logic [1:0] blk, div;
  logic       tick;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_ctl_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .prog_o(prog), .erase_o(erase), .verify_o(verify),
    .hv_en_o(hv), .blk_sel_o(blk), .div_sel_o(div), .pump_tick_o(tick)
  );

  function automatic logic [7:0] ref_next(input logic [7:0] cur, input logic [7:0] wd);
    logic np, ne, nh, nv;
    np = wd[0]; ne = wd[1];
    if ((np && ne) || (np && !cur[0] && cur[1]) || (ne && !cur[1] && cur[0])) begin
      np = cur[0]; ne = cur[1];
    end
    nh = wd[3] && (np || ne);
    nv = wd[2];
    if (cur[3] || nh) nv = 1'b0;
    return {wd[7:4], nh, nv, ne, np};
  endfunction

  function automatic string ref_tag(input logic [7:0] cur, input logic [7:0] wd);
    logic [7:0] n;
    n = ref_next(cur, wd);
    if (wd[1:0] != n[1:0])              return "R2";
    if (wd[3] && !n[3])                 return "R3";
    if (cur[3] && wd[2])                return "R4";
    if (n[3] && !cur[3] && wd[2])       return "R5";
    if (cur[3] && !n[3])                return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state(input string tag);
    check(tag, {24'd0, rd_data}, {24'd0, model});
    check(tag, {24'd0, div, blk, hv, verify, erase, prog}, {24'd0, model});
    if (!model[3]) check("R9", {31'd0, tick}, 32'd0);
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [7:0] d);
    string tg;
    tg = ref_tag(model, d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model = ref_next(model, d);
    check_state(tg);
  endtask

  task automatic tick_run(input int unsigned f, input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      check(tag, {31'd0, tick}, {31'd0, ((i % f) == f - 1)});
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned f;
    repeat (3) @(negedge clk);
    check("R1", {24'd0, rd_data, tick}, 32'd0);
    check("R1", {24'd0, div, blk, hv, verify, erase, prog}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: strobe low with data present
    wr_data = 8'hFF;
    @(negedge clk);
    check("R11", {24'd0, rd_data}, 32'd0);
    wr(8'h09);
    wr_data = 8'h06;
    repeat (2) @(negedge clk);
    check("R11", {24'd0, rd_data}, 32'h09);
    wr(8'h00);

    // directed interlock cases
    wr(8'h03);                       // R2 both set at once
    wr(8'h01); wr(8'h02);            // R2 set erase while prog stored
    wr(8'h08);                       // R3 hv without op
    wr(8'h05); wr(8'h09);            // R5 verify cleared on hv rise
    wr(8'h0D);                       // R4 verify while hv
    wr(8'h04);                       // R6 drop op clears hv
    wr(8'hB0); wr(8'h40);            // R7 plain fields

    // sweep of stored state x low nibble
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 16; b++) begin
        wr(8'(a));
        wr({4'(a), 4'(b)});
      end
    end

    // R8/R9 divide ratios
    for (int d = 0; d < 4; d++) begin
      f = (d == 0) ? 1 : (d == 3) ? 4 : 2;
      wr(8'h00);
      wr({2'(d), 6'b000001});
      check("R9", {31'd0, tick}, 32'd0);
      wr({2'(d), 6'b001001});
      tick_run(f, 12, "R8");
      wr({2'(d), 6'b000000});
      check("R9", {31'd0, tick}, 32'd0);
    end

    // R10 restart on divide change between equal ratios
    wr(8'h00);
    wr(8'h41);
    wr(8'h49);                       // div=01, hv on, cycle 0 no tick
    check("R10", {31'd0, tick}, 32'd0);
    wr(8'h89);                       // div=10, restart
    tick_run(2, 6, "R10");
    wr(8'hC9);                       // div=11 restart mid-run
    tick_run(4, 8, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule